// File: doc/BRIEF.md
# SPI Clock Divisor Search Unit

This unit picks the two divisor settings for a serial clock generator: an even prescale value and a post-divider value. The serial bit rate works out to the input clock frequency divided by prescale times (post-divider plus one). A caller supplies the input clock frequency in hertz and the requested bit rate, then pulses start. The unit runs a search and reports the slowest-indexed pair that does not run the serial clock faster than requested. If no pair qualifies, it raises an error flag instead.

The requested rate is first pulled into the reachable range. Rates above half the input clock are lowered to half the input clock. Rates below the slowest reachable rate are raised to that rate. The slowest reachable rate is the clock divided by a lower-bound divisor, truncated.

The search order is fixed. The prescale is the outer loop. The post-divider is the inner loop, and it sweeps its full range for every prescale. One candidate is tested per cycle. The test uses a multiply-and-compare, not a divider. The divider registers themselves and any programming of them are left to the surrounding logic.

Top module: `spi_div_search`

## Requirements
- R1: A requested rate above floor(freq/2) is treated as floor(freq/2). Such a request returns prescale 2 and post-divider 0, with done one cycle after the start edge.
- R2: A requested rate below floor(freq/LOW_DIV) is treated as that bound. LOW_DIV defaults to PRE_LAST×(POST_LAST+1). The result equals the result for a request of exactly the bound.
- R3: Candidates are tried in a fixed order.
  - The prescale runs through even values from 2 to PRE_LAST, ascending, as the outer loop.
  - The post-divider runs from 0 to POST_LAST, ascending, as the inner loop.
  - Candidate number n (counting from 0) is tested n+1 cycles after the start edge, and done rises after that edge.
- R4: The result is the first candidate, in the order of R3, for which floor(freq/(prescale×(post+1))) ≤ clamped rate. err_o is 0 with such a result.
- R5: When no candidate qualifies, done pulses with err_o=1 after the last candidate is tested. prescale_o and postdiv_o keep their previous values.
- R6: done_o is high for exactly one cycle per search. err_o, prescale_o and postdiv_o change only together with done_o, and hold until the next completion.
- R7: A start pulse while a search is running is ignored. The running search finishes with its own result and latency, and done_o pulses only once.
- R8: After reset, done_o=0, err_o=0, prescale_o=0 and postdiv_o=0.
- R9: prescale_o is always even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a search when the unit is idle |
| freq_i | input | CLK_W | Input clock frequency, in Hz, sampled at start |
| rate_i | input | CLK_W | Requested bit rate, in Hz, sampled at start |
| done_o | output | 1 | One-cycle pulse when a search ends |
| err_o | output | 1 | Set when the last search found no candidate |
| prescale_o | output | PRE_W | Selected even prescale |
| postdiv_o | output | POST_W | Selected post-divider |

## Verification
The hardest condition to reach from the ports is the failure path. With the default parameters, the lower clamp guarantees that the final candidate always qualifies, so exhaustion cannot happen. The bench therefore adds a second instance with a short search range (prescales 2 and 4, post-dividers 0 to 3) and keeps the default lower bound. That instance first completes a successful search, then gets a low request that nothing in its range can meet, which checks both the error flag and that the outputs are retained.

The bench also covers a very low request on the default instance, which walks almost the whole candidate space. Finally, it issues a second start in the middle of a running search.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;

  typedef enum logic {
    SRCH_IDLE = 1'b0,
    SRCH_RUN  = 1'b1
  } srch_state_e;

  localparam int unsigned PRE_FIRST = 2;
  localparam int unsigned PRE_STEP  = 2;

endpackage

// File: rtl/spi_div_clamp.sv
module spi_div_clamp #(
  parameter int unsigned CLK_W   = 32,
  parameter int unsigned LOW_DIV = 65024
) (
  input  logic [CLK_W-1:0] freq_i,
  input  logic [CLK_W-1:0] rate_i,
  output logic [CLK_W-1:0] rate_o
);

  localparam logic [CLK_W-1:0] LOW_DIV_W = CLK_W'(LOW_DIV);

  function automatic logic [CLK_W-1:0] slowest_rate(input logic [CLK_W-1:0] f);
    return f / LOW_DIV_W;
  endfunction

  function automatic logic [CLK_W-1:0] fastest_rate(input logic [CLK_W-1:0] f);
    return f >> 1;
  endfunction

  logic [CLK_W-1:0] lo_bound;
  logic [CLK_W-1:0] hi_bound;

  always_comb begin
    lo_bound = slowest_rate(freq_i);
    hi_bound = fastest_rate(freq_i);
    if (rate_i < lo_bound)      rate_o = lo_bound;
    else if (rate_i > hi_bound) rate_o = hi_bound;
    else                        rate_o = rate_i;
  end

endmodule

// File: rtl/spi_div_cand_gen.sv
module spi_div_cand_gen #(
  parameter int unsigned PRE_W     = 8,
  parameter int unsigned POST_W    = 8,
  parameter int unsigned PRE_LAST  = 254,
  parameter int unsigned POST_LAST = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  output logic [PRE_W-1:0]  pre_o,
  output logic [POST_W-1:0] post_o,
  output logic              last_o
);

  localparam logic [PRE_W-1:0]  PRE_INIT = PRE_W'(spi_div_pkg::PRE_FIRST);
  localparam logic [PRE_W-1:0]  PRE_INC  = PRE_W'(spi_div_pkg::PRE_STEP);
  localparam logic [PRE_W-1:0]  PRE_END  = PRE_W'(PRE_LAST);
  localparam logic [POST_W-1:0] POST_END = POST_W'(POST_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_o  <= PRE_INIT;
      post_o <= '0;
    end else if (load_i) begin
      pre_o  <= PRE_INIT;
      post_o <= '0;
    end else if (step_i) begin
      if (post_o == POST_END) begin
        post_o <= '0;
        pre_o  <= pre_o + PRE_INC;
      end else begin
        post_o <= post_o + POST_W'(1);
      end
    end
  end

  assign last_o = (pre_o == PRE_END) && (post_o == POST_END);

endmodule

// File: rtl/spi_div_accept.sv
module spi_div_accept #(
  parameter int unsigned CLK_W  = 32,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned POST_W = 8
) (
  input  logic [CLK_W-1:0]  freq_i,
  input  logic [CLK_W-1:0]  tgt_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic [POST_W-1:0] post_i,
  output logic              ok_o
);

  localparam int unsigned PROD_W = CLK_W + 1 + PRE_W + POST_W + 1;

  // floor(f / d) <= t  holds exactly when  f < (t + 1) * d
  function automatic logic not_faster(input logic [CLK_W-1:0]  f,
                                      input logic [CLK_W-1:0]  t,
                                      input logic [PRE_W-1:0]  p,
                                      input logic [POST_W-1:0] q);
    logic [PROD_W-1:0] lim;
    lim = (PROD_W'(t) + PROD_W'(1)) * PROD_W'(p) * (PROD_W'(q) + PROD_W'(1));
    return PROD_W'(f) < lim;
  endfunction

  assign ok_o = not_faster(freq_i, tgt_i, pre_i, post_i);

endmodule

// File: rtl/spi_div_search.sv
module spi_div_search #(
  parameter int unsigned CLK_W     = 32,
  parameter int unsigned PRE_W     = 8,
  parameter int unsigned POST_W    = 8,
  parameter int unsigned PRE_LAST  = 254,
  parameter int unsigned POST_LAST = 255,
  parameter int unsigned LOW_DIV   = PRE_LAST * (POST_LAST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CLK_W-1:0]  freq_i,
  input  logic [CLK_W-1:0]  rate_i,
  output logic              done_o,
  output logic              err_o,
  output logic [PRE_W-1:0]  prescale_o,
  output logic [POST_W-1:0] postdiv_o
);

  import spi_div_pkg::*;

  srch_state_e      state_q;
  logic [CLK_W-1:0] freq_q;
  logic [CLK_W-1:0] tgt_q;
  logic [CLK_W-1:0] rate_clamped;

  logic [PRE_W-1:0]  cand_pre;
  logic [POST_W-1:0] cand_post;
  logic              cand_last;
  logic              cand_ok;

  // named events, also watched by the checker
  logic srch_busy;
  logic srch_launch;
  logic srch_hit;
  logic srch_exhaust;
  logic srch_step;

  assign srch_busy    = (state_q == SRCH_RUN);
  assign srch_launch  = start_i && !srch_busy;
  assign srch_hit     = srch_busy && cand_ok;
  assign srch_exhaust = srch_busy && !cand_ok && cand_last;
  assign srch_step    = srch_busy && !cand_ok && !cand_last;

  spi_div_clamp #(
    .CLK_W   (CLK_W),
    .LOW_DIV (LOW_DIV)
  ) u_clamp (
    .freq_i (freq_i),
    .rate_i (rate_i),
    .rate_o (rate_clamped)
  );

  spi_div_cand_gen #(
    .PRE_W     (PRE_W),
    .POST_W    (POST_W),
    .PRE_LAST  (PRE_LAST),
    .POST_LAST (POST_LAST)
  ) u_cand (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (srch_launch),
    .step_i (srch_step),
    .pre_o  (cand_pre),
    .post_o (cand_post),
    .last_o (cand_last)
  );

  spi_div_accept #(
    .CLK_W  (CLK_W),
    .PRE_W  (PRE_W),
    .POST_W (POST_W)
  ) u_accept (
    .freq_i (freq_q),
    .tgt_i  (tgt_q),
    .pre_i  (cand_pre),
    .post_i (cand_post),
    .ok_o   (cand_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SRCH_IDLE;
      freq_q     <= '0;
      tgt_q      <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      prescale_o <= '0;
      postdiv_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (srch_launch) begin
        state_q <= SRCH_RUN;
        freq_q  <= freq_i;
        tgt_q   <= rate_clamped;
      end
      if (srch_hit) begin
        state_q    <= SRCH_IDLE;
        prescale_o <= cand_pre;
        postdiv_o  <= cand_post;
        err_o      <= 1'b0;
        done_o     <= 1'b1;
      end else if (srch_exhaust) begin
        state_q <= SRCH_IDLE;
        err_o   <= 1'b1;
        done_o  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_div_search_chk.sv
module spi_div_search_chk #(
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned POST_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done_o,
  input logic              err_o,
  input logic [PRE_W-1:0]  prescale_o,
  input logic [POST_W-1:0] postdiv_o,
  input logic              srch_busy,
  input logic              srch_hit,
  input logic              srch_exhaust
);

  // R6: completion is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: results move only together with done
  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(prescale_o) && $stable(postdiv_o) && $stable(err_o)));

  // R5: a failed search keeps the last divisors
  a_r5_fail_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> ($stable(prescale_o) && $stable(postdiv_o)));

  // R4: an accepted candidate completes next cycle without error
  a_r4_hit_done: assert property (@(posedge clk) disable iff (!rst_n)
    srch_hit |=> (done_o && !err_o));

  // R5: running out of candidates completes with error
  a_r5_exhaust_err: assert property (@(posedge clk) disable iff (!rst_n)
    srch_exhaust |=> (done_o && err_o));

  // R3 / R7: the search keeps running until it hits or runs out
  a_r3_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_busy && !srch_hit && !srch_exhaust) |=> srch_busy);

  // R9: prescale output stays even
  a_r9_prescale_even: assert property (@(posedge clk) disable iff (!rst_n)
    !prescale_o[0]);

endmodule

bind spi_div_search spi_div_search_chk #(
  .PRE_W  (PRE_W),
  .POST_W (POST_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .done_o       (done_o),
  .err_o        (err_o),
  .prescale_o   (prescale_o),
  .postdiv_o    (postdiv_o),
  .srch_busy    (srch_busy),
  .srch_hit     (srch_hit),
  .srch_exhaust (srch_exhaust)
);

// File: tb/test_spi_div_search.sv
module test_spi_div_search;

  localparam int SM_PRE_LAST  = 4;
  localparam int SM_POST_LAST = 3;
  localparam int DEF_LOW_DIV  = 254 * 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_m = 1'b0;
  logic        start_s = 1'b0;
  logic [31:0] freq = '0;
  logic [31:0] rate = '0;

  logic        done_m, err_m, done_s, err_s;
  logic [7:0]  pre_m, post_m, pre_s, post_s;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spi_div_search i_spi_div_search (
    .clk (clk), .rst_n (rst_n), .start_i (start_m),
    .freq_i (freq), .rate_i (rate),
    .done_o (done_m), .err_o (err_m),
    .prescale_o (pre_m), .postdiv_o (post_m)
  );

  spi_div_search #(
    .PRE_LAST (SM_PRE_LAST), .POST_LAST (SM_POST_LAST), .LOW_DIV (DEF_LOW_DIV)
  ) i_spi_div_search_narrow (
    .clk (clk), .rst_n (rst_n), .start_i (start_s),
    .freq_i (freq), .rate_i (rate),
    .done_o (done_s), .err_o (err_s),
    .prescale_o (pre_s), .postdiv_o (post_s)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // restated search: plain division, linear walk
  task automatic ref_search(input longint unsigned f, input longint unsigned r,
                            input int pl, input int ql, input int ld,
                            output int pre, output int post, output int lat,
                            output bit fail);
    longint unsigned t;
    longint unsigned lo;
    longint unsigned hi;
    int idx;
    lo = f / ld;
    hi = f / 2;
    t = r;
    if (t < lo) t = lo;
    if (t > hi) t = hi;
    fail = 1'b1; pre = 0; post = 0; idx = 0;
    for (int p = 2; p <= pl && fail; p += 2) begin
      for (int q = 0; q <= ql && fail; q++) begin
        if (f / longint'(p * (q + 1)) <= t) begin
          pre = p; post = q; fail = 1'b0;
        end else begin
          idx++;
        end
      end
    end
    lat = fail ? idx : idx + 1;
  endtask

  task automatic run_search(input bit sm, input longint unsigned f,
                            input longint unsigned r, input string req);
    int epre, epost, elat, cycles;
    bit efail, got;
    int prev_pre, prev_post;
    if (sm) ref_search(f, r, SM_PRE_LAST, SM_POST_LAST, DEF_LOW_DIV, epre, epost, elat, efail);
    else    ref_search(f, r, 254, 255, DEF_LOW_DIV, epre, epost, elat, efail);
    prev_pre  = sm ? pre_s : pre_m;
    prev_post = sm ? post_s : post_m;
    @(negedge clk);
    freq = f[31:0];
    rate = r[31:0];
    if (sm) start_s = 1'b1; else start_m = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_s = 1'b0; start_m = 1'b0;
    cycles = 0; got = 1'b0;
    while (!got && cycles < 40000) begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
      got = sm ? done_s : done_m;
    end
    chk(got && cycles == elat, req, "latency(R3)", cycles, elat);
    chk((sm ? err_s : err_m) == efail, req, "err", sm ? err_s : err_m, efail);
    if (efail) begin
      chk((sm ? pre_s : pre_m) == prev_pre, "R5", "kept prescale", sm ? pre_s : pre_m, prev_pre);
      chk((sm ? post_s : post_m) == prev_post, "R5", "kept postdiv", sm ? post_s : post_m, prev_post);
    end else begin
      chk((sm ? pre_s : pre_m) == epre, req, "prescale(R4)", sm ? pre_s : pre_m, epre);
      chk((sm ? post_s : post_m) == epost, req, "postdiv(R4)", sm ? post_s : post_m, epost);
    end
    chk(!(sm ? pre_s[0] : pre_m[0]), "R9", "prescale even", sm ? pre_s : pre_m, 0);
    @(negedge clk);
    chk(!(sm ? done_s : done_m), "R6", "done one cycle", sm ? done_s : done_m, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int epre, epost, elat, cycles;
    bit efail;
    logic [7:0] hold_pre, hold_post;
    logic hold_err;
    void'($urandom(32'h5D1C_0042));

    repeat (3) @(negedge clk);
    chk(done_m == 0, "R8", "reset done", done_m, 0);
    chk(err_m == 0, "R8", "reset err", err_m, 0);
    chk(pre_m == 0, "R8", "reset prescale", pre_m, 0);
    chk(post_m == 0, "R8", "reset postdiv", post_m, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: request above half the clock
    run_search(0, 1_000_000, 900_000, "R1");
    run_search(0, 64'hFFFF_FFFF, 64'hFFFF_FFFF, "R1");
    run_search(0, 0, 5, "R1");
    // R4: exact boundary and one below
    run_search(0, 12_000_000, 1_000_000, "R4");
    run_search(0, 12_000_000, 999_999, "R4");
    // R2: below the slowest reachable rate, and exactly at it
    run_search(0, 100_000_000, 0, "R2");
    hold_pre = pre_m; hold_post = post_m;
    run_search(0, 100_000_000, 100_000_000 / DEF_LOW_DIV, "R2");
    chk(pre_m == hold_pre && post_m == hold_post, "R2", "same as bound", pre_m, hold_pre);

    // R6: results hold between completions
    hold_pre = pre_m; hold_post = post_m; hold_err = err_m;
    repeat (5) @(negedge clk);
    chk(pre_m == hold_pre && post_m == hold_post && err_m == hold_err,
        "R6", "held after done", pre_m, hold_pre);

    // R5: narrow instance success, then a search with no answer
    run_search(1, 1000, 100, "R4");
    run_search(1, 1_000_000, 100, "R5");
    chk(err_s == 1, "R6", "err held", err_s, 1);

    // R7: second start during a running search
    ref_search(50_000_000, 200_000, 254, 255, DEF_LOW_DIV, epre, epost, elat, efail);
    @(negedge clk);
    freq = 50_000_000; rate = 200_000; start_m = 1'b1;
    @(posedge clk); @(negedge clk);
    start_m = 1'b0; cycles = 0;
    repeat (10) begin @(posedge clk); cycles++; @(negedge clk); end
    freq = 8_000_000; rate = 4_000_000; start_m = 1'b1;
    @(posedge clk); cycles++; @(negedge clk);
    start_m = 1'b0;
    while (!done_m && cycles < 40000) begin @(posedge clk); cycles++; @(negedge clk); end
    chk(cycles == elat, "R7", "latency unchanged", cycles, elat);
    chk(pre_m == epre && post_m == epost, "R7", "original result", pre_m, epre);
    repeat (3) begin
      @(negedge clk);
      chk(!done_m, "R7", "no second done", done_m, 0);
    end

    // random requests near reachable divisors
    for (int k = 0; k < 30; k++) begin
      longint unsigned f, r;
      int d;
      f = longint'($urandom_range(32'hFFFF_FFFF, 1000));
      d = $urandom_range(500, 2);
      r = f / d + longint'($urandom_range(3, 0));
      run_search(0, f, r, "R4");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule